// File: doc/BRIEF.md
# Punctured Convolutional Encoder with I/Q Symbol Mapper

This block takes a serial stream of data bits through a valid/ready handshake and codes each bit with a rate-1/2 convolutional code of constraint length 7. The first generator, 171 octal, gives the in-phase symbol and the second, 133 octal, gives the quadrature symbol. A rate select can thin the coded stream to rate 3/4. In that mode, within each period of three input bits, the first bit keeps both symbols, the second keeps only its quadrature symbol, and the third keeps only its in-phase symbol. Four symbols survive from each three bits.

The surviving symbols are grouped in order into pairs. The earlier symbol of a pair goes to the in-phase output and the later one to the quadrature output. In QPSK mode each pair is presented on two parallel outputs with one strobe. In BPSK mode the pair is sent as two serial symbols on consecutive cycles, and a select input picks which of the two goes first. The input is held off while the second serial symbol is still waiting, so no data bit is dropped.

Rate, mode and order selections are sampled only at the start of a puncture period. They are also sampled on reset and on a resync pulse, so a period is never split between two settings.

Top module: `pconv_iq_mapper`

## Requirements
- R1: A synchronous active-high reset clears the encoder history to all zeros and returns the puncture phase to 0. In the cycle after reset, `pair_valid` and `ser_valid` are both 0. After reset, the first bit accepted is coded as if all earlier bits were 0.
- R2: With `rate_sel`=0 (rate 1/2), each accepted bit b produces one pair. The I symbol is the XOR of b and the inputs 1, 2, 3 and 6 bits earlier (171 octal). The Q symbol is the XOR of b and the inputs 2, 3, 5 and 6 bits earlier (133 octal). The pair appears on the outputs one cycle after the accepting edge.
- R3: With `rate_sel`=1 (rate 3/4), the phases of a period are 0, 1 and 2. The bit at phase 0 yields the pair (I of bit 1, Q of bit 1). The bit at phase 1 yields no output in the following cycle. The bit at phase 2 yields the pair (Q of bit 2, I of bit 3).
- R4: With `mode_sel`=0 (QPSK), a pair is shown on `out_i`/`out_q` with a one-cycle `pair_valid` pulse, and `ser_valid` stays 0.
- R5: With `mode_sel`=1 (BPSK), a pair is sent on `ser_bit` over two consecutive cycles, each marked by `ser_valid`, starting one cycle after the accepting edge. `pair_valid` stays 0.
- R6: In BPSK, `q_first`=0 sends the pair's I symbol first and `q_first`=1 sends its Q symbol first.
- R7: `in_ready` is 0 during the cycle in which the first serial symbol is shown. The second symbol follows in the next cycle, and no bit is accepted in between.
- R8: A change of `rate_sel`, `mode_sel` or `q_first` is ignored while the puncture phase is 1 or 2. It takes effect with the next bit accepted at phase 0.
- R9: A `resync` pulse holds `in_ready` at 0 for that cycle. It returns the puncture phase to 0 and samples the selects, so the next accepted bit starts a new period under the new settings.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_bit | input | 1 | Data bit to encode |
| in_valid | input | 1 | `in_bit` is valid |
| in_ready | output | 1 | Block can accept a bit this cycle |
| rate_sel | input | 1 | 0: rate 1/2, 1: rate 3/4 |
| mode_sel | input | 1 | 0: QPSK parallel pair, 1: BPSK serial |
| q_first | input | 1 | BPSK order: 1 sends the Q symbol of each pair first |
| resync | input | 1 | Restart the puncture period and sample the selects |
| out_i | output | 1 | In-phase symbol of the current pair |
| out_q | output | 1 | Quadrature symbol of the current pair |
| pair_valid | output | 1 | One-cycle strobe for `out_i`/`out_q` |
| ser_bit | output | 1 | Serial BPSK symbol |
| ser_valid | output | 1 | One-cycle strobe for `ser_bit` |

## Verification
The bench goes after the middle bit of a rate-3/4 period. A design that emitted it, or that held the wrong symbol, would show an extra pair or a swapped (Q2, I3) pair. It changes the rate and mode part-way through a period; a design that sampled the selects on every bit would split the period and drop or add symbols. It also checks BPSK order under both settings of the order select, and checks that the input is held off while the second serial symbol is pending. A design that kept accepting would overwrite that symbol. Finally, it issues a resync in mid-period and a reset after a stretch of traffic, which shows any phase counter or history register that failed to clear.

// File: rtl/pconv_pkg.sv
package pconv_pkg;

  typedef enum logic { RATE_HALF = 1'b0, RATE_3Q = 1'b1 } rate_e;
  typedef enum logic { MOD_QPSK = 1'b0, MOD_BPSK = 1'b1 } mod_e;

  // One output pair: earlier kept symbol on I, later on Q.
  typedef struct packed {
    logic sym_i;
    logic sym_q;
  } sym_pair_t;

  // Modulo-2 inner product of the code window with a generator.
  function automatic logic gen_parity(input logic [31:0] win,
                                      input logic [31:0] poly);
    return ^(win & poly);
  endfunction

  // Which phases of a puncture period emit a pair at rate 3/4.
  function automatic logic phase_emits(input rate_e rate,
                                       input logic [1:0] phase);
    return (rate == RATE_HALF) || (phase == 2'd0) || (phase == 2'd2);
  endfunction

endpackage

// File: rtl/pconv_shift_encoder.sv
module pconv_shift_encoder
  import pconv_pkg::*;
#(
  parameter int unsigned K  = 7,
  parameter logic [31:0] G1 = 32'o171,
  parameter logic [31:0] G2 = 32'o133
) (
  input  logic clk,
  input  logic rst,
  input  logic accept,
  input  logic din,
  output logic g1,
  output logic g2
);
  localparam int unsigned HIST_W = K - 1;

  logic [HIST_W-1:0] hist_q;   // MSB = most recent earlier bit
  logic [K-1:0]      window;   // MSB = current bit, LSB = oldest

  assign window = {din, hist_q};
  assign g1     = gen_parity(32'(window), G1);
  assign g2     = gen_parity(32'(window), G2);

  always_ff @(posedge clk) begin
    if (rst)         hist_q <= '0;
    else if (accept) hist_q <= window[K-1:1];
  end

endmodule

// File: rtl/pconv_puncturer.sv
module pconv_puncturer
  import pconv_pkg::*;
#(
  parameter int unsigned PERIOD = 3,
  localparam int unsigned PH_W  = $clog2(PERIOD)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            resync,
  input  logic            accept,
  input  rate_e           rate,
  input  logic            g1,
  input  logic            g2,
  output logic            emit,
  output sym_pair_t       pair,
  output logic [PH_W-1:0] phase
);
  logic [PH_W-1:0] phase_q;
  logic            held_q;    // Q symbol of the phase-1 bit
  logic            fresh;     // both symbols of this bit survive

  assign phase = phase_q;
  assign fresh = (rate == RATE_HALF) || (phase_q == '0);
  assign emit  = accept && phase_emits(rate, 2'(phase_q));
  assign pair.sym_i = fresh ? g1 : held_q;
  assign pair.sym_q = fresh ? g2 : g1;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
      held_q  <= 1'b0;
    end else if (resync) begin
      phase_q <= '0;
    end else if (accept) begin
      if (rate == RATE_HALF) begin
        phase_q <= '0;
      end else begin
        if (phase_q == PH_W'(1)) held_q <= g2;
        phase_q <= (phase_q == PH_W'(PERIOD - 1)) ? '0 : phase_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/pconv_iq_serializer.sv
module pconv_iq_serializer
  import pconv_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      emit,
  input  sym_pair_t pair,
  input  mod_e      mode,
  input  logic      q_first,
  output logic      out_i,
  output logic      out_q,
  output logic      pair_valid,
  output logic      ser_bit,
  output logic      ser_valid,
  output logic      pend
);
  logic pend_bit_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_i      <= 1'b0;
      out_q      <= 1'b0;
      pair_valid <= 1'b0;
      ser_bit    <= 1'b0;
      ser_valid  <= 1'b0;
      pend       <= 1'b0;
      pend_bit_q <= 1'b0;
    end else begin
      pair_valid <= 1'b0;
      ser_valid  <= 1'b0;
      if (pend) begin
        ser_bit   <= pend_bit_q;
        ser_valid <= 1'b1;
        pend      <= 1'b0;
      end else if (emit) begin
        if (mode == MOD_BPSK) begin
          ser_bit    <= q_first ? pair.sym_q : pair.sym_i;
          pend_bit_q <= q_first ? pair.sym_i : pair.sym_q;
          ser_valid  <= 1'b1;
          pend       <= 1'b1;
        end else begin
          out_i      <= pair.sym_i;
          out_q      <= pair.sym_q;
          pair_valid <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/pconv_iq_mapper.sv
module pconv_iq_mapper
  import pconv_pkg::*;
#(
  parameter int unsigned K      = 7,
  parameter logic [31:0] G1     = 32'o171,
  parameter logic [31:0] G2     = 32'o133,
  parameter int unsigned PERIOD = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic in_bit,
  input  logic in_valid,
  output logic in_ready,
  input  logic rate_sel,
  input  logic mode_sel,
  input  logic q_first,
  input  logic resync,
  output logic out_i,
  output logic out_q,
  output logic pair_valid,
  output logic ser_bit,
  output logic ser_valid
);
  localparam int unsigned PH_W = $clog2(PERIOD);

  // Named internal events, visible to the bound checker.
  logic            accept;
  logic            emit;
  logic            pend;
  logic            cfg_load;
  logic [PH_W-1:0] phase;
  logic            g1, g2;
  sym_pair_t       pair;

  rate_e act_rate, cur_rate;
  mod_e  act_mode, cur_mode;
  logic  act_qf,   cur_qf;

  assign in_ready = !rst && !pend && !resync;
  assign accept   = in_valid && in_ready;
  assign cfg_load = (phase == '0) && !pend;

  assign cur_rate = cfg_load ? rate_e'(rate_sel) : act_rate;
  assign cur_mode = cfg_load ? mod_e'(mode_sel)  : act_mode;
  assign cur_qf   = cfg_load ? q_first           : act_qf;

  always_ff @(posedge clk) begin
    if (rst || resync) begin
      act_rate <= rate_e'(rate_sel);
      act_mode <= mod_e'(mode_sel);
      act_qf   <= q_first;
    end else begin
      act_rate <= cur_rate;
      act_mode <= cur_mode;
      act_qf   <= cur_qf;
    end
  end

  pconv_shift_encoder #(.K(K), .G1(G1), .G2(G2)) u_enc (
    .clk    (clk),
    .rst    (rst),
    .accept (accept),
    .din    (in_bit),
    .g1     (g1),
    .g2     (g2)
  );

  pconv_puncturer #(.PERIOD(PERIOD)) u_punc (
    .clk    (clk),
    .rst    (rst),
    .resync (resync),
    .accept (accept),
    .rate   (cur_rate),
    .g1     (g1),
    .g2     (g2),
    .emit   (emit),
    .pair   (pair),
    .phase  (phase)
  );

  pconv_iq_serializer u_ser (
    .clk        (clk),
    .rst        (rst),
    .emit       (emit),
    .pair       (pair),
    .mode       (cur_mode),
    .q_first    (cur_qf),
    .out_i      (out_i),
    .out_q      (out_q),
    .pair_valid (pair_valid),
    .ser_bit    (ser_bit),
    .ser_valid  (ser_valid),
    .pend       (pend)
  );

endmodule

// File: rtl/pconv_iq_mapper_chk.sv
module pconv_iq_mapper_chk #(
  parameter int unsigned PH_W = 2
) (
  input logic            clk,
  input logic            rst,
  input logic            resync,
  input logic            in_valid,
  input logic            in_ready,
  input logic            pair_valid,
  input logic            ser_valid,
  input logic            emit,
  input logic            pend,
  input logic [PH_W-1:0] phase,
  input logic            act_rate
);
  logic acc;
  assign acc = in_valid && in_ready;

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!pair_valid && !ser_valid));

  assert_emit_lands_R2: assert property (@(posedge clk) disable iff (rst)
    emit |=> (pair_valid || ser_valid));

  assert_mid_phase_silent_R3: assert property (@(posedge clk) disable iff (rst)
    (acc && phase == PH_W'(1)) |=> (!pair_valid && !ser_valid));

  assert_phase_range_R3: assert property (@(posedge clk) disable iff (rst)
    phase < PH_W'(3));

  assert_single_path_R4: assert property (@(posedge clk) disable iff (rst)
    !(pair_valid && ser_valid));

  assert_second_follows_R7: assert property (@(posedge clk) disable iff (rst)
    pend |=> (ser_valid && !pend));

  assert_cfg_held_R8: assert property (@(posedge clk) disable iff (rst)
    (phase != '0 && !resync) |=> $stable(act_rate));

  assert_resync_restart_R9: assert property (@(posedge clk) disable iff (rst)
    resync |=> (phase == '0));

endmodule

bind pconv_iq_mapper pconv_iq_mapper_chk #(.PH_W(PH_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .resync     (resync),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .pair_valid (pair_valid),
  .ser_valid  (ser_valid),
  .emit       (emit),
  .pend       (pend),
  .phase      (phase),
  .act_rate   (act_rate)
);

// File: tb/tb_pconv_iq_mapper.sv
module tb_pconv_iq_mapper;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_bit = 1'b0, in_valid = 1'b0;
  logic rate_sel = 1'b0, mode_sel = 1'b0, q_first = 1'b0, resync = 1'b0;
  logic in_ready, out_i, out_q, pair_valid, ser_bit, ser_valid;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;   // 50 MHz

  pconv_iq_mapper dut (
    .clk(clk), .rst(rst), .in_bit(in_bit), .in_valid(in_valid),
    .in_ready(in_ready), .rate_sel(rate_sel), .mode_sel(mode_sel),
    .q_first(q_first), .resync(resync), .out_i(out_i), .out_q(out_q),
    .pair_valid(pair_valid), .ser_bit(ser_bit), .ser_valid(ser_valid)
  );

  // Reference model state
  logic [5:0] h;          // h[0] = one bit ago ... h[5] = six bits ago
  int         ph;
  logic       held;
  logic       m_rate, m_mode, m_qf;

  // Entry = {rate, mode, q_first, bit}
  localparam logic [3:0] VEC [25] = '{
    4'b0001, 4'b0000, 4'b0001, 4'b0001, 4'b0000, 4'b0001,
    4'b1001, 4'b1000, 4'b1000, 4'b1001, 4'b1001, 4'b1000,
    4'b0101, 4'b0100, 4'b0101, 4'b0101,
    4'b1111, 4'b1110, 4'b1111, 4'b1110, 4'b1110, 4'b1111,
    4'b1001, 4'b0100, 4'b0110
  };

  task automatic chk(input string req, input string what,
                     input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    h = '0; ph = 0; held = 1'b0;
  endtask

  task automatic push(input logic r, input logic m, input logic qf,
                      input logic b);
    logic e1, e2, si, sq, emits, midchg;
    string tag;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    rate_sel = r; mode_sel = m; q_first = qf; in_bit = b; in_valid = 1'b1;
    midchg = (ph != 0) && (r != m_rate || m != m_mode);
    if (ph == 0) begin m_rate = r; m_mode = m; m_qf = qf; end
    // 171: delays 0,1,2,3,6   133: delays 0,2,3,5,6
    e1 = b ^ h[0] ^ h[1] ^ h[2] ^ h[5];
    e2 = b ^ h[1] ^ h[2] ^ h[4] ^ h[5];
    h  = {h[4:0], b};
    emits = 1'b1; si = e1; sq = e2;
    if (m_rate) begin
      if (ph == 1) begin emits = 1'b0; held = e2; end
      else if (ph == 2) begin si = held; sq = e1; end
      ph = (ph == 2) ? 0 : ph + 1;
    end
    if (midchg)      tag = "R8";
    else if (m_mode) tag = m_qf ? "R6" : "R5";
    else             tag = m_rate ? "R3" : "R2";
    @(negedge clk);
    in_valid = 1'b0;
    if (!emits) begin
      chk("R3", "punctured bit pair_valid", pair_valid, 1'b0);
      chk("R3", "punctured bit ser_valid", ser_valid, 1'b0);
    end else if (!m_mode) begin
      chk(tag, "pair_valid", pair_valid, 1'b1);
      chk(tag, "out_i", out_i, si);
      chk(tag, "out_q", out_q, sq);
      chk("R4", "ser_valid in QPSK", ser_valid, 1'b0);
    end else begin
      chk(tag, "first ser_valid", ser_valid, 1'b1);
      chk(tag, "first ser_bit", ser_bit, m_qf ? sq : si);
      chk("R5", "pair_valid in BPSK", pair_valid, 1'b0);
      chk("R7", "in_ready while second pending", in_ready, 1'b0);
      @(negedge clk);
      chk(tag, "second ser_valid", ser_valid, 1'b1);
      chk(tag, "second ser_bit", ser_bit, m_qf ? si : sq);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin : main
    m_rate = 1'b0; m_mode = 1'b0; m_qf = 1'b0;
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "pair_valid after reset", pair_valid, 1'b0);
    chk("R1", "ser_valid after reset", ser_valid, 1'b0);
    chk("R1", "in_ready after reset", in_ready, 1'b1);

    // Table walk: rate/mode/order patterns incl. mid-period change (R8)
    foreach (VEC[i]) push(VEC[i][3], VEC[i][2], VEC[i][1], VEC[i][0]);

    // R9: resync in mid-period at rate 3/4, then switch to rate 1/2
    push(1'b1, 1'b0, 1'b0, 1'b1);           // phase now 1
    @(negedge clk);
    resync = 1'b1; rate_sel = 1'b0;
    #1 chk("R9", "in_ready during resync", in_ready, 1'b0);
    @(negedge clk);
    resync = 1'b0; ph = 0;
    push(1'b0, 1'b0, 1'b0, 1'b1);           // must emit a full pair
    push(1'b0, 1'b0, 1'b0, 1'b0);

    // R1: reset after traffic clears history and phase
    push(1'b1, 1'b0, 1'b0, 1'b1);           // leave phase at 1
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R1", "pair_valid held low in reset", pair_valid, 1'b0);
    model_reset();
    push(1'b1, 1'b0, 1'b0, 1'b1);           // phase 0: I=1, Q=1
    push(1'b1, 1'b1, 1'b0, 1'b1);
    push(1'b1, 1'b1, 1'b0, 1'b0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule